// File: doc/BRIEF.md
# Clocked Serial Shift Port

A byte-wide, clock-synchronous serial port. Software writes one byte to launch a transfer. The port then sends that byte on its data-out pin while it collects a byte from its data-in pin, one bit per serial clock. After the eighth bit it raises a sticky completion flag and gives a one-cycle interrupt pulse. The received byte is then available on a parallel output.

There are two clocking modes. In master mode the port drives the serial clock itself from the system clock. In slave mode it follows a serial clock supplied from outside. That external clock is first passed through a two-stage synchroniser and an edge detector. The bit order is chosen per transfer: most-significant bit first or least-significant bit first. Both the clock mode and the bit order are latched when a transfer starts.

The serial clock rests high. Incoming data is sampled on each rising serial-clock edge. Outgoing data moves to the next bit only after a falling edge, so the first bit is already on the data-out pin before the first falling edge arrives.

Top module: `sync_shift_port`

## Requirements
- R1: A write (`wrEn`=1) while `busy`=0 starts a transfer. In the next cycle `busy`=1 and `done`=0. Exactly 8 bits are exchanged in each direction, and then `busy` returns to 0 and `done` goes to 1.
- R2: With `lsbFirst`=0 at the start, `sdo` presents `wrData[7]` down to `wrData[0]`, one per serial-clock period. The first bit sampled from `sdi` lands in `rxData[7]`.
- R3: With `lsbFirst`=1 at the start, `sdo` presents `wrData[0]` up to `wrData[7]`, and the first sampled bit lands in `rxData[0]`. The order is latched at the start, so changing `lsbFirst` mid-transfer has no effect.
- R4: With `extClkMode`=0 (master), `sckOe`=1. `sckOut` is high whenever the port is idle and falls only while a transfer runs. Each serial-clock period is 4 system cycles low followed by 4 high. `done` reads 1 exactly 64 cycles after the write was sampled.
- R5: `sdi` is sampled on each rising serial-clock edge. `sdo` carries the first bit before the first falling edge, changes only after falling edges, and holds still while idle.
- R6: With `extClkMode`=1 (slave), `sckOe`=0. `sckIn` is synchronised through two flops and accepted at any rate whose high and low phases each last at least 4 system cycles. `done` is set within 3 cycles after the 8th rising edge and not before it.
- R7: A write while `busy`=1 is ignored. The running transfer's outgoing bits, received byte and completion time are unchanged.
- R8: Once `done`=1, `rxData` holds the received byte in the selected bit order.
- R9: `done` is cleared by an accepted write or by `clrDone`=1. When `clrDone` coincides with transfer completion, `done` ends set.
- R10: `irq` pulses high for exactly one cycle, in the cycle in which `done` first reads 1 for a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe that launches a transfer |
| wrData | input | 8 | Byte to send |
| lsbFirst | input | 1 | 1: least-significant bit first, 0: most-significant first |
| extClkMode | input | 1 | 1: follow external serial clock, 0: generate it |
| clrDone | input | 1 | Clear strobe for the completion flag |
| sckIn | input | 1 | External serial clock (slave mode) |
| sckOut | output | 1 | Generated serial clock, idles high |
| sckOe | output | 1 | Output enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rxData | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: completion setting the flag, and the software clear strobe removing it. In master mode the completion cycle is fixed at 64 cycles after the write. The bench therefore raises `clrDone` for exactly that cycle on several transfers, expects `done` to read 1 afterwards, and then expects a lone clear to drop it. Writes that arrive in the middle of a transfer, together with a flipped bit order, are checked to leave the outgoing bits, the received byte and the completion timing untouched.

// File: rtl/shift_port_pkg.sv
package shift_port_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // accept software byte
    logic capture;  // rising serial-clock edge: sample sdi
    logic advance;  // falling serial-clock edge after a capture: next bit out
    logic finish;   // last bit done
  } shiftStrobes_t;
endpackage

// File: rtl/shift_port_ctrl.sv
module shift_port_ctrl
  import shift_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          extClkMode,
  input  logic          clrDone,
  input  logic          sckIn,
  output logic          sckOut,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output shiftStrobes_t strb
);
  localparam int PH_W    = $clog2(2 * HALF_CYC);
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int LAST_PH = 2 * HALF_CYC - 1;
  localparam int MID_PH  = HALF_CYC - 1;

  logic [1:0]       syncQ;
  logic             prevQ;
  logic             extRise, extFall;
  logic             busyQ, useExtQ, sckQ, doneQ, irqQ;
  logic [PH_W-1:0]  phaseQ;
  logic [CNT_W-1:0] bitCntQ;
  logic             phEnd, phMid, lastBit, allBits;

  // external clock synchroniser and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], sckIn};
      prevQ <= syncQ[1];
    end
  end

  assign extRise = syncQ[1] & ~prevQ;
  assign extFall = ~syncQ[1] & prevQ;

  assign phEnd   = (phaseQ == PH_W'(LAST_PH));
  assign phMid   = (phaseQ == PH_W'(MID_PH));
  assign lastBit = (bitCntQ == CNT_W'(DATA_W - 1));
  assign allBits = (bitCntQ == CNT_W'(DATA_W));

  always_comb begin
    strb.load = wrEn & ~busyQ;
    if (useExtQ) begin
      strb.capture = busyQ & extRise;
      strb.advance = busyQ & extFall & (bitCntQ != '0);
      strb.finish  = busyQ & extRise & lastBit;
    end else begin
      strb.capture = busyQ & phMid & ~allBits;
      strb.advance = busyQ & phEnd & ~allBits;
      strb.finish  = busyQ & phEnd & allBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      useExtQ <= 1'b0;
      sckQ    <= 1'b1;
      phaseQ  <= '0;
      bitCntQ <= '0;
      doneQ   <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      irqQ <= strb.finish;
      if (strb.finish)                doneQ <= 1'b1;
      else if (strb.load || clrDone)  doneQ <= 1'b0;

      if (strb.load) begin
        busyQ   <= 1'b1;
        useExtQ <= extClkMode;
        phaseQ  <= '0;
        bitCntQ <= '0;
        sckQ    <= extClkMode;  // master: first falling edge now
      end else begin
        if (strb.finish) busyQ <= 1'b0;
        if (strb.capture) bitCntQ <= bitCntQ + 1'b1;
        if (busyQ && !useExtQ) begin
          phaseQ <= phEnd ? '0 : phaseQ + 1'b1;
          if (strb.capture)      sckQ <= 1'b1;
          else if (strb.advance) sckQ <= 1'b0;
        end
      end
    end
  end

  assign sckOut = sckQ;
  assign busy   = busyQ;
  assign done   = doneQ;
  assign irq    = irqQ;
endmodule

// File: rtl/shift_port_dp.sv
module shift_port_dp
  import shift_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lsbFirst,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] txQ, rxQ, rxOutQ;
  logic [DATA_W-1:0] wrRev, nextRx, finalRx, finalRev;
  logic              orderQ;

  // both shift registers always run MSB-first; the other order is
  // obtained by mirroring the byte at load and at completion
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign wrRev[i]    = wrData[MSB - i];
    assign finalRev[i] = finalRx[MSB - i];
  end

  assign nextRx  = {rxQ[MSB-1:0], sdi};
  assign finalRx = strb.capture ? nextRx : rxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ    <= '0;
      rxQ    <= '0;
      rxOutQ <= '0;
      orderQ <= 1'b0;
    end else begin
      if (strb.load) begin
        txQ    <= lsbFirst ? wrRev : wrData;
        orderQ <= lsbFirst;
      end else if (strb.advance) begin
        txQ <= {txQ[MSB-1:0], 1'b0};
      end
      if (strb.capture) rxQ <= nextRx;
      if (strb.finish)  rxOutQ <= orderQ ? finalRev : finalRx;
    end
  end

  assign sdo    = txQ[MSB];
  assign rxData = rxOutQ;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import shift_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lsbFirst,
  input  logic              extClkMode,
  input  logic              clrDone,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  shiftStrobes_t strb;

  shift_port_ctrl #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .extClkMode(extClkMode),
    .clrDone(clrDone), .sckIn(sckIn), .sckOut(sckOut), .busy(busy),
    .done(done), .irq(irq), .strb(strb)
  );

  shift_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .lsbFirst(lsbFirst), .sdi(sdi), .sdo(sdo), .rxData(rxData)
  );

  assign sckOe = ~extClkMode;
endmodule

// File: rtl/shift_port_chk.sv
module shift_port_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic sckOut,
  input logic sdo,
  input logic busy,
  input logic done,
  input logic irq
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> (busy && !done));
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut);
  // R4
  fall_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sckOut) |-> busy);
  // R5
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrEn) |=> $stable(sdo));
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R10
  irq_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);
  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind sync_shift_port shift_port_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .sckOut(sckOut), .sdo(sdo),
  .busy(busy), .done(done), .irq(irq)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, lsbFirst = 1'b0, extClkMode = 1'b0, clrDone = 1'b0;
  logic sckIn = 1'b1, sdi = 1'b0;
  logic [7:0] wrData = '0;
  logic sckOut, sckOe, sdo, busy, done, irq;
  logic [7:0] rxData;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sync_shift_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .lsbFirst(lsbFirst),
    .extClkMode(extClkMode), .clrDone(clrDone), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .sdi(sdi), .sdo(sdo), .rxData(rxData), .busy(busy),
    .done(done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bitAt(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] rxv, input bit lsb,
                            input bit midWrite, input bit clrAtEnd);
    logic [7:0] sdoSeq, expSeq;
    int rises, lowRun, highRun, badRun, doneAt, irqCnt;
    logic prevSck;
    @(negedge clk);
    extClkMode = 1'b0; lsbFirst = lsb; wrData = tx; wrEn = 1'b1;
    sdi = bitAt(rxv, 0, lsb);
    @(negedge clk);
    wrEn = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R1 busy after write", busy, 1);
    sdoSeq = '0; rises = 0; lowRun = 0; highRun = 0; badRun = 0;
    doneAt = 0; irqCnt = 0; prevSck = 1'b1;
    for (int n = 1; n <= 75; n++) begin
      if (sckOut && !prevSck) begin
        if (lowRun != 4) badRun++;
        if (rises < 8) sdoSeq[rises] = sdo;
        rises++;
        highRun = 0;
        if (rises < 8) sdi = bitAt(rxv, rises, lsb);
      end
      if (!sckOut && prevSck) begin
        if (n > 1 && highRun != 4) badRun++;
        lowRun = 0;
      end
      if (sckOut) highRun++; else lowRun++;
      prevSck = sckOut;
      if (done && doneAt == 0) doneAt = n;
      if (irq) irqCnt++;
      if (midWrite && n == 20) begin wrEn = 1'b1; wrData = ~tx; lsbFirst = ~lsb; end
      if (midWrite && n == 21) begin wrEn = 1'b0; lsbFirst = lsb; end
      if (clrAtEnd && n == 64) clrDone = 1'b1;
      if (clrAtEnd && n == 65) clrDone = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 8; k++) expSeq[k] = bitAt(tx, k, lsb);
    check(rises == 8, "R1 eight rising edges", rises, 8);
    check(badRun == 0, "R4 phase widths 4/4", badRun, 0);
    check(doneAt == 65, "R4 completion latency", doneAt, 65);
    check(sckOut === 1'b1 && busy === 1'b0, "R4 idle high after transfer", sckOut, 1);
    check(sdoSeq == expSeq, lsb ? "R3 sdo order (R5 R7)" : "R2 sdo order (R5 R7)",
          sdoSeq, expSeq);
    check(rxData == rxv, lsb ? "R3 rx byte (R8 R7)" : "R2 rx byte (R8 R7)", rxData, rxv);
    check(irqCnt == 1, "R10 single irq pulse", irqCnt, 1);
    check(done === 1'b1, clrAtEnd ? "R9 finish beats clear" : "R1 done set", done, 1);
    if (clrAtEnd) begin
      clrDone = 1'b1;
      @(negedge clk);
      clrDone = 1'b0;
      check(done === 1'b0, "R9 clear strobe", done, 0);
    end
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input logic [7:0] rxv, input bit lsb,
                           input int half);
    logic [7:0] sdoSeq, expSeq;
    @(negedge clk);
    extClkMode = 1'b1; sckIn = 1'b1; lsbFirst = lsb; wrData = tx; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check(sckOe === 1'b0, "R6 clock pin released", sckOe, 0);
    check(sdo === bitAt(tx, 0, lsb), "R5 first bit before first fall", sdo, bitAt(tx, 0, lsb));
    check(done === 1'b0, "R9 write clears done", done, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      sckIn = 1'b0; sdi = bitAt(rxv, k, lsb);
      repeat (half) @(negedge clk);
      sdoSeq[k] = sdo;
      if (k == 7) check(done === 1'b0, "R6 no early completion", done, 0);
      sckIn = 1'b1;
      repeat (half) @(negedge clk);
    end
    for (int k = 0; k < 8; k++) expSeq[k] = bitAt(tx, k, lsb);
    check(done === 1'b1 && busy === 1'b0, "R6 done after 8th rise", done, 1);
    check(sdoSeq == expSeq, "R6 sdo sequence (R5)", sdoSeq, expSeq);
    check(rxData == rxv, lsb ? "R6 rx byte R3 R8" : "R6 rx byte R2 R8", rxData, rxv);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sckOut === 1'b1 && busy === 1'b0 && done === 1'b0 && irq === 1'b0,
          "R4 reset state", {sckOut, busy, done, irq}, 4'b1000);
    check(sckOe === 1'b1, "R4 master drives clock", sckOe, 1);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] tv, rv;
      tv = 8'(v);
      rv = 8'(v * 37 + 11);
      masterXfer(tv, rv, tv[0], (v % 17) == 5, (v % 29) == 3);
    end
    for (int v = 0; v < 64; v++) begin
      logic [7:0] tv, rv;
      tv = 8'(v * 5 + 3);
      rv = 8'(v * 73 + 200);
      slaveXfer(tv, rv, tv[1], (v % 2 == 1) ? 4 : 9);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule